// File: doc/BRIEF.md
# Auxiliary Timer with Capture and Reload Roles

This block is a WIDTH-bit auxiliary counter that works beside a core timer. In its stand-alone roles it runs as a free timer, a gated timer or an edge counter. Each of these counts up or down. The free and gated timers step on a power-of-two prescaled tick. The edge counter steps on selected edges of the auxiliary input pin.

The same register can take one of three other roles toward the core timer:
- **Cascade:** it counts the core timer's overflow and underflow strobes, so the pair acts as one double-width counter.
- **Capture:** it latches the core timer's value on a selected pin edge.
- **Reload:** it drives a one-cycle load strobe, with its own value, into the core timer. The trigger is a core overflow/underflow or a selected pin edge.

A CPU write port can overwrite the register at any time, and that write always wins. A one-cycle interrupt pulse reports wraps, captures and reloads.

Top module: `aux_tmr_unit`

## Requirements
- R1: After reset, `tmr_val` is 0 and `irq` and `core_ld` are low.
- R2: With `cfg_role`=0 (free timer) and `cfg_run`=1, the register steps by one on every prescaler tick. A tick comes every 2^`cfg_psel` clocks. The step is +1 when `cfg_down`=0 and -1 when `cfg_down`=1.
- R3: With `cfg_role`=1 (gated timer), the register steps like R2 only in clocks where `aux_in` is high.
- R4: With `cfg_role`=2 (edge counter), the register steps by one in `cfg_down`'s direction on each selected `aux_in` edge. `cfg_edge` selects the edges: 0 none, 1 rising, 2 falling, 3 both.
- R5: In roles 0 to 3, a step from all-ones up to 0, or from 0 down to all-ones, raises `irq` for one clock together with the wrapped value.
- R6: With `cfg_role`=3 (cascade) and `cfg_run`=1, a `core_ovf` strobe adds one and a `core_unf` strobe subtracts one. A wrap raises `irq` as in R5.
- R7: With `cfg_role`=4 (capture), a selected `aux_in` edge loads `core_val` into the register one clock later and pulses `irq`.
- R8: With `cfg_role`=5 (reload), a trigger in one clock makes `core_ld` high in the next clock, with `core_ld_val` equal to the register value at the trigger, and pulses `irq`. The trigger is a selected `aux_in` edge, or a `core_ovf`/`core_unf` strobe when `cfg_rld_core`=1. With `cfg_rld_core`=0 the strobes do not trigger.
- R9: In the capture and reload roles the register never counts. Outside a capture and a CPU write it keeps its value.
- R10: A CPU write (`cpu_we`) sets the register to `cpu_wdata` in the next clock. It takes priority over any step or capture in that clock, and that suppressed update raises no `irq`.
- R11: `cfg_role` values 6 and 7 leave the block idle: the register holds, and `irq` and `core_ld` stay low.
- R12: In roles 0 to 3, `cfg_run`=0 stops all counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_role | input | 3 | Role: 0 timer, 1 gated, 2 edge counter, 3 cascade, 4 capture, 5 reload, 6-7 idle |
| cfg_run | input | 1 | Counting enable for roles 0 to 3 |
| cfg_down | input | 1 | Count direction for roles 0 to 2 (1 = down) |
| cfg_psel | input | PSEL_W | Prescaler exponent; tick every 2^cfg_psel clocks |
| cfg_edge | input | 2 | Pin edge select: 0 none, 1 rise, 2 fall, 3 both |
| cfg_rld_core | input | 1 | Allow core overflow/underflow to trigger a reload |
| aux_in | input | 1 | Auxiliary pin (gate, count or trigger), synchronous to clk |
| core_ovf | input | 1 | Core timer overflow strobe |
| core_unf | input | 1 | Core timer underflow strobe |
| core_val | input | WIDTH | Core timer current value |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | WIDTH | CPU write data |
| tmr_val | output | WIDTH | Register value (CPU read data) |
| irq | output | 1 | One-clock interrupt request pulse |
| core_ld | output | 1 | Load strobe to the core timer |
| core_ld_val | output | WIDTH | Value for the core timer to load |

## Verification
The assertions assume that `aux_in` is already synchronous to `clk`. They also assume that `core_ovf` and `core_unf` are never high in the same clock, because the cascade check expects a pure increment on an overflow strobe. The bench drives every input at the falling edge and raises only one core strobe at a time. It holds `aux_in` low through reset, so the edge detector starts from a known level. The sweeps run over all edge selects, both directions and all prescaler settings, at the default width.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;

   // Role codes carried on cfg_role
   typedef enum logic [2:0] {
      ROLE_TIMER   = 3'd0,
      ROLE_GATED   = 3'd1,
      ROLE_COUNTER = 3'd2,
      ROLE_CASCADE = 3'd3,
      ROLE_CAPTURE = 3'd4,
      ROLE_RELOAD  = 3'd5,
      ROLE_IDLE_A  = 3'd6,
      ROLE_IDLE_B  = 3'd7
   } role_e;

   // Pin edge selection carried on cfg_edge
   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_e;

endpackage

// File: rtl/aux_tmr_presc.sv
// Free-running prescaler producing a tick every 2^sel clocks.
module aux_tmr_presc #(
   parameter int unsigned PSEL_W   = 2,
   parameter bit          PRESC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] sel,
   output logic              tick
);
   localparam int unsigned DIV_W = (1 << PSEL_W) - 1;

   generate
      if (PSEL_W < 1 || PSEL_W > 4) begin : g_bad_psel
         $error("aux_tmr_presc: PSEL_W must lie in 1..4");
      end

      if (PRESC_EN) begin : g_div
         logic [DIV_W-1:0] cnt_q;
         logic [DIV_W-1:0] mask;

         always_comb mask = DIV_W'((32'd1 << sel) - 32'd1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + DIV_W'(1);
         end

         assign tick = ((cnt_q & mask) == mask);
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/aux_tmr_edge.sv
// Pin edge detector with selectable polarity.
module aux_tmr_edge
   import aux_tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sel,
   output logic       hit
);
   logic pin_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin;
   end

   assign rise = pin & ~pin_q;
   assign fall = ~pin & pin_q;

   always_comb begin
      unique case (edge_e'(sel))
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   // A falling edge must never be reported under a rising-only select
   assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd1 && hit) |-> pin);
endmodule

// File: rtl/aux_tmr_ctrl.sv
// Role decoder: turns the role, pin and core strobes into step/capture/reload requests.
module aux_tmr_ctrl
   import aux_tmr_pkg::*;
#(
   parameter bit GATE_HIGH = 1'b1
) (
   input  logic [2:0] role,
   input  logic       run,
   input  logic       dir_dn,
   input  logic       tick,
   input  logic       pin,
   input  logic       hit,
   input  logic       core_ovf,
   input  logic       core_unf,
   input  logic       rld_core,
   output logic       step_en,
   output logic       step_dn,
   output logic       cap_trig,
   output logic       rld_trig
);
   logic gate_open;

   generate
      if (GATE_HIGH) begin : g_gate_hi
         assign gate_open = pin;
      end else begin : g_gate_lo
         assign gate_open = ~pin;
      end
   endgenerate

   always_comb begin
      step_en  = 1'b0;
      step_dn  = dir_dn;
      cap_trig = 1'b0;
      rld_trig = 1'b0;
      unique case (role_e'(role))
         ROLE_TIMER:   step_en = run & tick;
         ROLE_GATED:   step_en = run & tick & gate_open;
         ROLE_COUNTER: step_en = run & hit;
         ROLE_CASCADE: begin
            step_en = run & (core_ovf ^ core_unf);
            step_dn = core_unf;
         end
         ROLE_CAPTURE: cap_trig = hit;
         ROLE_RELOAD:  rld_trig = hit | (rld_core & (core_ovf | core_unf));
         default: ;
      endcase
   end
endmodule

// File: rtl/aux_tmr_unit.sv
// Auxiliary timer: independent counter, cascade extension, capture latch or reload source.
module aux_tmr_unit
   import aux_tmr_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned PSEL_W    = 2,
   parameter bit          PRESC_EN  = 1'b1,
   parameter bit          GATE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_role,
   input  logic              cfg_run,
   input  logic              cfg_down,
   input  logic [PSEL_W-1:0] cfg_psel,
   input  logic [1:0]        cfg_edge,
   input  logic              cfg_rld_core,
   input  logic              aux_in,
   input  logic              core_ovf,
   input  logic              core_unf,
   input  logic [WIDTH-1:0]  core_val,
   input  logic              cpu_we,
   input  logic [WIDTH-1:0]  cpu_wdata,
   output logic [WIDTH-1:0]  tmr_val,
   output logic              irq,
   output logic              core_ld,
   output logic [WIDTH-1:0]  core_ld_val
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("aux_tmr_unit: WIDTH must lie in 2..64");
      end
   endgenerate

   logic             tick, hit;
   logic             step_en, step_dn, cap_trig, rld_trig;
   logic             wrap;
   logic [WIDTH-1:0] tmr_q, tmr_d;
   logic             irq_q, ld_q;
   logic [WIDTH-1:0] ld_val_q;

   aux_tmr_presc #(.PSEL_W(PSEL_W), .PRESC_EN(PRESC_EN)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (cfg_psel),
      .tick (tick)
   );

   aux_tmr_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (aux_in),
      .sel  (cfg_edge),
      .hit  (hit)
   );

   aux_tmr_ctrl #(.GATE_HIGH(GATE_HIGH)) u_ctrl (
      .role    (cfg_role),
      .run     (cfg_run),
      .dir_dn  (cfg_down),
      .tick    (tick),
      .pin     (aux_in),
      .hit     (hit),
      .core_ovf(core_ovf),
      .core_unf(core_unf),
      .rld_core(cfg_rld_core),
      .step_en (step_en),
      .step_dn (step_dn),
      .cap_trig(cap_trig),
      .rld_trig(rld_trig)
   );

   assign wrap = step_en & (step_dn ? (tmr_q == '0) : (tmr_q == MAXV));

   // Update priority: CPU write, then capture, then counting step
   always_comb begin
      if (cpu_we)        tmr_d = cpu_wdata;
      else if (cap_trig) tmr_d = core_val;
      else if (step_en)  tmr_d = step_dn ? tmr_q - ONE : tmr_q + ONE;
      else               tmr_d = tmr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         irq_q    <= 1'b0;
         ld_q     <= 1'b0;
         ld_val_q <= '0;
      end else begin
         tmr_q <= tmr_d;
         irq_q <= (~cpu_we & (cap_trig | wrap)) | rld_trig;
         ld_q  <= rld_trig;
         if (rld_trig) ld_val_q <= tmr_q;
      end
   end

   assign tmr_val     = tmr_q;
   assign irq         = irq_q;
   assign core_ld     = ld_q;
   assign core_ld_val = ld_val_q;

   // ---------------- assertions ----------------
   assert_cpu_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_we |=> tmr_val == $past(cpu_wdata));

   assert_capture_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role == 3'd4 && hit && !cpu_we) |=> (tmr_val == $past(core_val)) && irq);

   assert_reload_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role == 3'd5 && hit) |=> core_ld && (core_ld_val == $past(tmr_val)));

   assert_no_count_cap_rld_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_role == 3'd4 || cfg_role == 3'd5) && !cpu_we && !hit) |=> $stable(tmr_val));

   assert_idle_role_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role[2:1] == 2'b11 && !cpu_we) |=> $stable(tmr_val) && !irq && !core_ld);

   assert_cascade_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role == 3'd3 && cfg_run && core_ovf && !core_unf && !cpu_we)
      |=> tmr_val == $past(tmr_val) + ONE);

   assert_stop_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role[2] == 1'b0 && !cfg_run && !cpu_we) |=> $stable(tmr_val) && !irq);

   assert_load_only_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_role != 3'd5) |=> !core_ld);
endmodule

// File: tb/aux_tmr_unit_tb.sv
`timescale 1ns/1ps
module aux_tmr_unit_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [2:0]   cfg_role;
   logic         cfg_run, cfg_down, cfg_rld_core;
   logic [1:0]   cfg_psel;
   logic [1:0]   cfg_edge;
   logic         aux_in, core_ovf, core_unf;
   logic [W-1:0] core_val;
   logic         cpu_we;
   logic [W-1:0] cpu_wdata;
   logic [W-1:0] tmr_val, core_ld_val;
   logic         irq, core_ld;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   aux_tmr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role), .cfg_run(cfg_run),
      .cfg_down(cfg_down), .cfg_psel(cfg_psel), .cfg_edge(cfg_edge),
      .cfg_rld_core(cfg_rld_core), .aux_in(aux_in), .core_ovf(core_ovf),
      .core_unf(core_unf), .core_val(core_val), .cpu_we(cpu_we),
      .cpu_wdata(cpu_wdata), .tmr_val(tmr_val), .irq(irq),
      .core_ld(core_ld), .core_ld_val(core_ld_val)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // advance one clock; return at the falling edge
   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [W-1:0] v);
      cpu_we = 1'b1; cpu_wdata = v;
      step(1);
      cpu_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_role = 3'd6; cfg_run = 1'b0; cfg_down = 1'b0;
      cfg_psel = 2'd0; cfg_edge = 2'd0; cfg_rld_core = 1'b0; aux_in = 1'b0;
      core_ovf = 1'b0; core_unf = 1'b0; core_val = '0; cpu_we = 1'b0; cpu_wdata = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 tmr", 32'(tmr_val), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 core_ld", 32'(core_ld), 0);

      // R10 plain write
      wr(16'h1234);
      chk("R10 write", 32'(tmr_val), 32'h1234);

      // R2 timer up/down
      cfg_role = 3'd0; cfg_run = 1'b1; cfg_psel = 2'd0;
      wr(16'h0010);
      chk("R10 write over count", 32'(tmr_val), 32'h0010);
      step(5);
      chk("R2 up", 32'(tmr_val), 32'h0015);
      cfg_down = 1'b1;
      step(5);
      chk("R2 down", 32'(tmr_val), 32'h0010);
      cfg_down = 1'b0;

      // R2 prescaler sweep: 32 clocks give 32>>s ticks
      for (int s = 0; s < 4; s++) begin
         cfg_psel = 2'(s);
         wr(16'h0000);
         step(32);
         chk($sformatf("R2 presc %0d", s), 32'(tmr_val), 32'(32 >> s));
      end
      cfg_psel = 2'd0;

      // R12 stop
      cfg_run = 1'b0;
      wr(16'h0042);
      step(10);
      chk("R12 frozen", 32'(tmr_val), 32'h0042);
      cfg_run = 1'b1;

      // R5 wrap up
      wr(16'hFFFE);
      step(1);
      chk("R5 FFFF", 32'(tmr_val), 32'hFFFF);
      chk("R5 no irq", 32'(irq), 0);
      step(1);
      chk("R5 wrap up", 32'(tmr_val), 32'h0000);
      chk("R5 irq up", 32'(irq), 1);
      step(1);
      chk("R5 irq clear", 32'(irq), 0);
      // R5 wrap down
      cfg_down = 1'b1;
      wr(16'h0001);
      step(1);
      chk("R5 zero", 32'(tmr_val), 0);
      chk("R5 no irq dn", 32'(irq), 0);
      step(1);
      chk("R5 wrap dn", 32'(tmr_val), 32'hFFFF);
      chk("R5 irq dn", 32'(irq), 1);
      cfg_down = 1'b0;

      // R10 write at wrap: no irq
      wr(16'hFFFF);
      wr(16'h0500);
      chk("R10 write beats wrap", 32'(tmr_val), 32'h0500);
      chk("R10 no irq", 32'(irq), 0);

      // R3 gated
      cfg_role = 3'd1;
      wr(16'h0020);
      aux_in = 1'b1;
      step(6);
      aux_in = 1'b0;
      step(4);
      chk("R3 gated", 32'(tmr_val), 32'h0026);

      // R4 edge counter sweep
      cfg_role = 3'd2;
      for (int es = 0; es < 4; es++) begin
         for (int d = 0; d < 2; d++) begin
            int k;
            logic [W-1:0] e;
            cfg_edge = 2'(es); cfg_down = d[0];
            wr(16'h0100);
            for (int p = 0; p < 5; p++) begin
               aux_in = 1'b1; step(1);
               aux_in = 1'b0; step(1);
            end
            k = 5 * ((es & 1) + (es >> 1));
            e = d ? W'(16'h0100 - k) : W'(16'h0100 + k);
            chk($sformatf("R4 edge=%0d down=%0d", es, d), 32'(tmr_val), 32'(e));
         end
      end
      cfg_down = 1'b0;

      // R6 cascade
      cfg_role = 3'd3; cfg_edge = 2'd0;
      wr(16'hFFFF);
      core_ovf = 1'b1; step(1); core_ovf = 1'b0;
      chk("R6 ovf wrap", 32'(tmr_val), 0);
      chk("R6 irq", 32'(irq), 1);
      core_unf = 1'b1; step(1); core_unf = 1'b0;
      chk("R6 unf wrap", 32'(tmr_val), 32'hFFFF);
      for (int p = 0; p < 3; p++) begin
         core_ovf = 1'b1; step(1); core_ovf = 1'b0; step(1);
      end
      chk("R6 three ovf", 32'(tmr_val), 32'h0002);
      chk("R6 irq idle", 32'(irq), 0);
      step(4);
      chk("R6 no self count", 32'(tmr_val), 32'h0002);
      cfg_run = 1'b0;
      core_ovf = 1'b1; step(1); core_ovf = 1'b0;
      chk("R12 cascade stop", 32'(tmr_val), 32'h0002);
      cfg_run = 1'b1;

      // R7 capture sweep
      cfg_role = 3'd4; cfg_edge = 2'd1;
      wr(16'h0000);
      for (int i = 0; i < 8; i++) begin
         logic [W-1:0] cv;
         cv = W'(i * 16'h1111 + 3);
         core_val = cv; aux_in = 1'b1; step(1);
         chk($sformatf("R7 cap %0d", i), 32'(tmr_val), 32'(cv));
         chk("R7 irq", 32'(irq), 1);
         core_val = 16'h5A5A; aux_in = 1'b0; step(1);
         chk("R9 hold on fall", 32'(tmr_val), 32'(cv));
         chk("R9 no irq", 32'(irq), 0);
      end
      cfg_edge = 2'd3;
      core_val = 16'hBEEF; aux_in = 1'b1; step(1);
      chk("R7 both rise", 32'(tmr_val), 32'hBEEF);
      core_val = 16'hCAFE; aux_in = 1'b0; step(1);
      chk("R7 both fall", 32'(tmr_val), 32'hCAFE);
      // R10 write beats capture
      core_val = 16'h0001; aux_in = 1'b1;
      wr(16'h7777);
      chk("R10 beats capture", 32'(tmr_val), 32'h7777);
      chk("R10 capture irq off", 32'(irq), 0);
      aux_in = 1'b0; step(1);

      // R8 reload
      cfg_role = 3'd5; cfg_edge = 2'd0; cfg_rld_core = 1'b1;
      wr(16'hABCD);
      core_ovf = 1'b1; step(1); core_ovf = 1'b0;
      chk("R8 ld on ovf", 32'(core_ld), 1);
      chk("R8 ld val", 32'(core_ld_val), 32'hABCD);
      chk("R8 irq", 32'(irq), 1);
      step(1);
      chk("R8 ld one clk", 32'(core_ld), 0);
      core_unf = 1'b1; step(1); core_unf = 1'b0;
      chk("R8 ld on unf", 32'(core_ld), 1);
      cfg_rld_core = 1'b0;
      core_ovf = 1'b1; step(1); core_ovf = 1'b0;
      chk("R8 ovf disabled", 32'(core_ld), 0);
      cfg_edge = 2'd2;
      aux_in = 1'b1; step(1);
      chk("R8 no ld on rise", 32'(core_ld), 0);
      aux_in = 1'b0; step(1);
      chk("R8 ld on fall", 32'(core_ld), 1);
      chk("R8 ld val fall", 32'(core_ld_val), 32'hABCD);
      step(5);
      chk("R9 reload holds", 32'(tmr_val), 32'hABCD);

      // R11 idle roles
      for (int r = 6; r < 8; r++) begin
         cfg_role = 3'(r); cfg_edge = 2'd3; cfg_rld_core = 1'b1; cfg_run = 1'b1;
         wr(16'h3C3C);
         for (int p = 0; p < 4; p++) begin
            aux_in = ~aux_in; core_ovf = p[0]; core_val = 16'h1111;
            step(1);
            chk($sformatf("R11 role %0d tmr", r), 32'(tmr_val), 32'h3C3C);
            chk("R11 irq", 32'(irq), 0);
            chk("R11 core_ld", 32'(core_ld), 0);
         end
         core_ovf = 1'b0;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule